// File: doc/BRIEF.md
# DisplayPort Link Training Sequencer

This block is the control engine that brings a DisplayPort main link from an unconfigured state up to a trained state. It reaches the sink's configuration registers only through a request/response command port. The port is a stand-in for an AUX channel master: the block presents one read or write with an address, a byte count and write data, and holds it until a single-cycle acknowledge comes back. The acknowledge carries read data and an optional error flag.

After `start`, the sequencer masks the hotplug interrupt. It then writes the link rate and the lane count. Next it runs clock recovery with training pattern 1, which adjusts lane drive levels through a drive-level resolver submodule. Channel equalisation with pattern 2 follows, and finally training patterns are switched off. If training fails while the rate is high, the rate drops to 1.62 Gb/s and the sequence restarts from the rate write. The block finishes with a one-cycle `done` pulse, holds `success` and the rate that was used, and releases the hotplug mask. Waits are counted in clock cycles from a cycles-per-microsecond parameter.

Top module: `dplt_train_seq`

## Requirements
- R1: `hpd_mask` is 1 from the cycle after `start` is taken until the last command of the run. It is 0 in the `done` cycle and while idle, whatever the outcome, including an error abort.
- R2: Each training pass first writes the rate byte to address 0x100 and then the lane-count byte to 0x101. The lane-count byte is the lane count, with bit 7 set when `sink_rev` is 0x11 or higher.
- R3: Clock recovery writes 1 to 0x102. Its drive byte starts at 0x00. Each iteration writes the drive byte to all four bytes at 0x103 (a 4-byte write), waits at least CR_WAIT_US microseconds, then reads 2 status bytes at 0x202.
- R4: Lane n's status nibble is in status byte n/2, the low nibble for even n. Clock recovery passes only when bit 0 of every active lane's nibble is set. Nibbles of inactive lanes are ignored.
- R5: A try counter restarts at 1 whenever the swing field (drive bits 1:0) differs from the previous iteration. Clock recovery fails after 5 failed reads at one swing.
- R6: Clock recovery also fails as soon as a failing read sees bit 5 (pre-emphasis-limit flag) set in the current drive byte.
- R7: Between iterations the adjust request at 0x206 is read as 2 bytes, with nibbles laid out as in R4: bits 1:0 swing, bits 3:2 pre-emphasis. The new drive byte is `{2'b0, pflag, pre[1:0], sflag, swing[1:0]}`. Swing is the maximum over active lanes, capped at MAX_SWING, and sflag is set when swing reaches that cap. Pre-emphasis is the maximum over active lanes, capped at LEVEL_SUM minus swing, and pflag is set when pre-emphasis reaches that cap.
- R8: Equalisation writes 2 to 0x102. It then repeats: wait at least EQ_WAIT_US, read 3 bytes at 0x202. It makes at most 6 reads, with an adjust read and a drive write between reads.
- R9: Equalisation passes when bit 0 of the third status byte is set and every active lane nibble has bits 0, 1 and 2 set. Any active lane with bit 0 clear ends the phase as a failure.
- R10: Every pass that did not abort on an error ends by writing 0 to 0x102. If the pass failed and the rate is not 0x06, the rate becomes 0x06 and training repeats from R2.
- R11: An acknowledge with `cmd_err` set ends the run at once. The run ends with `success` 0, no further command and the rate unchanged.
- R12: After reset the block is idle with `done`, `success`, `hpd_mask` and `cmd_req` low. `done` is a one-cycle pulse. `success` and `rate_out` hold until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin training (taken when idle) |
| sink_rev | input | 8 | Sink capability version |
| lane_cnt | input | 3 | Active lanes: 1, 2 or 4 |
| rate_init | input | 8 | Starting rate code (0x0A high, 0x06 low) |
| cmd_req | output | 1 | Command valid, held until acknowledged |
| cmd_write | output | 1 | 1 = write, 0 = read |
| cmd_addr | output | 12 | Sink register address |
| cmd_len | output | 2 | Byte count minus one |
| cmd_wdata | output | 32 | Write bytes, first byte in bits 7:0 |
| cmd_ack | input | 1 | One-cycle completion |
| cmd_err | input | 1 | Error flag, valid with `cmd_ack` |
| cmd_rdata | input | 24 | Read bytes, first byte in bits 7:0 |
| hpd_mask | output | 1 | Hotplug interrupt mask |
| done | output | 1 | One-cycle end-of-training pulse |
| success | output | 1 | Result of the last run |
| rate_out | output | 8 | Rate used by the last run |

## Verification
The assertions assume that `sink_rev` and `lane_cnt` stay constant while a run is in progress. They also assume that `cmd_ack` only comes while `cmd_req` is high, and never in two adjacent cycles. The bench's sink model meets these assumptions by acknowledging on the falling edge after a request, then dropping the acknowledge on the next falling edge. It changes its configuration inputs only between runs, after `done`. The sink model returns zero nibbles for inactive lanes, so those lanes have to be ignored for a run to pass.

// File: rtl/dplt_pkg.sv
package dplt_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_BW, ST_LANES, ST_CR_PAT, ST_CR_COMMIT, ST_CR_WAIT,
        ST_CR_STAT, ST_CR_ADJ, ST_EQ_PAT, ST_EQ_WAIT, ST_EQ_STAT,
        ST_EQ_ADJ, ST_EQ_COMMIT, ST_STOP, ST_FIN
    } phase_t;

    typedef struct packed {
        logic        active;
        logic        write;
        logic [11:0] addr;
        logic [1:0]  len;
        logic [31:0] wdata;
    } cmd_t;

    localparam logic [11:0] ADR_RATE  = 12'h100;
    localparam logic [11:0] ADR_LANES = 12'h101;
    localparam logic [11:0] ADR_PAT   = 12'h102;
    localparam logic [11:0] ADR_DRIVE = 12'h103;
    localparam logic [11:0] ADR_STAT  = 12'h202;
    localparam logic [11:0] ADR_ADJ   = 12'h206;

    localparam logic [7:0] RATE_LOW  = 8'h06;
    localparam logic [7:0] REV_EF    = 8'h11;

    localparam int CR_TRIES = 5;
    localparam int EQ_TRIES = 6;

    function automatic cmd_t mk_cmd(logic wr, logic [11:0] a, logic [1:0] l,
                                    logic [31:0] d);
        cmd_t c;
        c.active = 1'b1;
        c.write  = wr;
        c.addr   = a;
        c.len    = l;
        c.wdata  = d;
        return c;
    endfunction

    function automatic logic [1:0] pre_cap(logic [1:0] swing, int sum);
        int r;
        r = sum - int'(swing);
        if (r < 0) r = 0;
        if (r > 3) r = 3;
        return 2'(r);
    endfunction

endpackage

// File: rtl/dplt_drive_resolve.sv
module dplt_drive_resolve
    import dplt_pkg::*;
#(
    parameter int LANES     = 4,
    parameter int MAX_SWING = 3,
    parameter int LEVEL_SUM = 3,
    localparam int LCW      = $clog2(LANES + 1)
) (
    input  logic [4*LANES-1:0] req,
    input  logic [LCW-1:0]     lane_cnt,
    output logic [7:0]         drive
);
    logic [1:0] sw_l [LANES];
    logic [1:0] pe_l [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic act;
        assign act     = lane_cnt > LCW'(g);
        assign sw_l[g] = act ? req[4*g +: 2]     : 2'd0;
        assign pe_l[g] = act ? req[4*g + 2 +: 2] : 2'd0;
    end

    always_comb begin
        logic [1:0] sw, pe, cap;
        logic       sf, pf;
        sw = '0;
        pe = '0;
        for (int i = 0; i < LANES; i++) begin
            if (sw_l[i] > sw) sw = sw_l[i];
            if (pe_l[i] > pe) pe = pe_l[i];
        end
        sf = 1'b0;
        if (int'(sw) >= MAX_SWING) begin
            sw = 2'(MAX_SWING);
            sf = 1'b1;
        end
        cap = pre_cap(sw, LEVEL_SUM);
        pf  = 1'b0;
        if (pe >= cap) begin
            pe = cap;
            pf = 1'b1;
        end
        drive = {2'b00, pf, pe, sf, sw};
    end
endmodule

// File: rtl/dplt_lane_eval.sv
module dplt_lane_eval #(
    parameter int LANES = 4,
    localparam int LCW  = $clog2(LANES + 1)
) (
    input  logic [4*LANES-1:0] stat,
    input  logic [LCW-1:0]     lane_cnt,
    output logic               all_cr,
    output logic               all_locked,
    output logic               cr_lost
);
    logic [LANES-1:0] act, cr, full;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign act[g]  = lane_cnt > LCW'(g);
        assign cr[g]   = stat[4*g];
        assign full[g] = &stat[4*g +: 3];
    end

    assign all_cr     = &(~act | cr);
    assign all_locked = &(~act | full);
    assign cr_lost    = |(act & ~cr);
endmodule

// File: rtl/dplt_delay.sv
module dplt_delay #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] cycles,
    output logic         expired
);
    logic [W-1:0] cnt;
    logic         run;

    assign expired = run && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            run <= 1'b0;
        end else if (load) begin
            cnt <= cycles - W'(1);
            run <= 1'b1;
        end else if (expired) begin
            run <= 1'b0;
        end else if (run) begin
            cnt <= cnt - W'(1);
        end
    end
endmodule

// File: rtl/dplt_train_seq.sv
module dplt_train_seq
    import dplt_pkg::*;
#(
    parameter int CYC_PER_US = 100,
    parameter int CR_WAIT_US = 100,
    parameter int EQ_WAIT_US = 400,
    parameter int LANES      = 4,
    parameter int MAX_SWING  = 3,
    parameter int LEVEL_SUM  = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [7:0]  sink_rev,
    input  logic [2:0]  lane_cnt,
    input  logic [7:0]  rate_init,
    output logic        cmd_req,
    output logic        cmd_write,
    output logic [11:0] cmd_addr,
    output logic [1:0]  cmd_len,
    output logic [31:0] cmd_wdata,
    input  logic        cmd_ack,
    input  logic        cmd_err,
    input  logic [23:0] cmd_rdata,
    output logic        hpd_mask,
    output logic        done,
    output logic        success,
    output logic [7:0]  rate_out
);
    localparam int CR_CYC = CR_WAIT_US * CYC_PER_US;
    localparam int EQ_CYC = EQ_WAIT_US * CYC_PER_US;
    localparam int MAXC   = (CR_CYC > EQ_CYC) ? CR_CYC : EQ_CYC;
    localparam int TW     = $clog2(MAXC + 1);

    phase_t     state;
    logic [7:0] rate, drive;
    logic [1:0] last_swing;
    logic       swing_seen, passed;
    logic [2:0] cr_tries, eq_tries;
    cmd_t       cmd;

    logic [7:0] new_drive;
    logic       all_cr, all_locked, cr_lost;
    logic       tmr_load, tmr_exp, ok_ack;
    logic [2:0] cr_next;
    logic [7:0] lane_byte;

    dplt_drive_resolve #(.LANES(LANES), .MAX_SWING(MAX_SWING),
                         .LEVEL_SUM(LEVEL_SUM)) u_resolve (
        .req(cmd_rdata[4*LANES-1:0]), .lane_cnt(lane_cnt), .drive(new_drive));

    dplt_lane_eval #(.LANES(LANES)) u_eval (
        .stat(cmd_rdata[4*LANES-1:0]), .lane_cnt(lane_cnt),
        .all_cr(all_cr), .all_locked(all_locked), .cr_lost(cr_lost));

    dplt_delay #(.W(TW)) u_delay (
        .clk(clk), .rst(rst), .load(tmr_load),
        .cycles((state == ST_CR_COMMIT) ? TW'(CR_CYC) : TW'(EQ_CYC)),
        .expired(tmr_exp));

    assign lane_byte = {(sink_rev >= REV_EF), 4'b0, lane_cnt};
    assign ok_ack    = cmd_ack && !cmd_err;
    assign tmr_load  = ok_ack && (state == ST_CR_COMMIT ||
                                  state == ST_EQ_PAT || state == ST_EQ_COMMIT);
    assign cr_next   = (swing_seen && last_swing == drive[1:0]) ?
                       cr_tries + 3'd1 : 3'd1;

    always_comb begin
        cmd = '0;
        unique case (state)
            ST_BW:        cmd = mk_cmd(1'b1, ADR_RATE,  2'd0, {24'b0, rate});
            ST_LANES:     cmd = mk_cmd(1'b1, ADR_LANES, 2'd0, {24'b0, lane_byte});
            ST_CR_PAT:    cmd = mk_cmd(1'b1, ADR_PAT,   2'd0, 32'd1);
            ST_EQ_PAT:    cmd = mk_cmd(1'b1, ADR_PAT,   2'd0, 32'd2);
            ST_STOP:      cmd = mk_cmd(1'b1, ADR_PAT,   2'd0, 32'd0);
            ST_CR_COMMIT,
            ST_EQ_COMMIT: cmd = mk_cmd(1'b1, ADR_DRIVE, 2'd3, {4{drive}});
            ST_CR_STAT:   cmd = mk_cmd(1'b0, ADR_STAT,  2'd1, 32'd0);
            ST_EQ_STAT:   cmd = mk_cmd(1'b0, ADR_STAT,  2'd2, 32'd0);
            ST_CR_ADJ,
            ST_EQ_ADJ:    cmd = mk_cmd(1'b0, ADR_ADJ,   2'd1, 32'd0);
            default:      cmd = '0;
        endcase
    end

    assign cmd_req   = cmd.active;
    assign cmd_write = cmd.write;
    assign cmd_addr  = cmd.addr;
    assign cmd_len   = cmd.len;
    assign cmd_wdata = cmd.wdata;
    assign hpd_mask  = (state != ST_IDLE) && (state != ST_FIN);
    assign done      = (state == ST_FIN);
    assign rate_out  = rate;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            rate       <= '0;
            drive      <= '0;
            last_swing <= '0;
            swing_seen <= 1'b0;
            passed     <= 1'b0;
            cr_tries   <= '0;
            eq_tries   <= '0;
            success    <= 1'b0;
        end else if (cmd.active && cmd_ack && cmd_err) begin
            passed  <= 1'b0;
            success <= 1'b0;
            state   <= ST_FIN;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    rate    <= rate_init;
                    success <= 1'b0;
                    state   <= ST_BW;
                end
                ST_BW:     if (ok_ack) state <= ST_LANES;
                ST_LANES:  if (ok_ack) state <= ST_CR_PAT;
                ST_CR_PAT: if (ok_ack) begin
                    drive      <= '0;
                    swing_seen <= 1'b0;
                    cr_tries   <= '0;
                    passed     <= 1'b0;
                    state      <= ST_CR_COMMIT;
                end
                ST_CR_COMMIT: if (ok_ack) state <= ST_CR_WAIT;
                ST_CR_WAIT:   if (tmr_exp) state <= ST_CR_STAT;
                ST_CR_STAT: if (ok_ack) begin
                    last_swing <= drive[1:0];
                    swing_seen <= 1'b1;
                    cr_tries   <= cr_next;
                    if (all_cr)
                        state <= ST_EQ_PAT;
                    else if (drive[5] || int'(cr_next) == CR_TRIES)
                        state <= ST_STOP;
                    else
                        state <= ST_CR_ADJ;
                end
                ST_CR_ADJ: if (ok_ack) begin
                    drive <= new_drive;
                    state <= ST_CR_COMMIT;
                end
                ST_EQ_PAT: if (ok_ack) begin
                    eq_tries <= '0;
                    state    <= ST_EQ_WAIT;
                end
                ST_EQ_WAIT: if (tmr_exp) state <= ST_EQ_STAT;
                ST_EQ_STAT: if (ok_ack) begin
                    if (cr_lost)
                        state <= ST_STOP;
                    else if (cmd_rdata[16] && all_locked) begin
                        passed <= 1'b1;
                        state  <= ST_STOP;
                    end else if (int'(eq_tries) == EQ_TRIES - 1)
                        state <= ST_STOP;
                    else begin
                        eq_tries <= eq_tries + 3'd1;
                        state    <= ST_EQ_ADJ;
                    end
                end
                ST_EQ_ADJ: if (ok_ack) begin
                    drive <= new_drive;
                    state <= ST_EQ_COMMIT;
                end
                ST_EQ_COMMIT: if (ok_ack) state <= ST_EQ_WAIT;
                ST_STOP: if (ok_ack) begin
                    if (passed) begin
                        success <= 1'b1;
                        state   <= ST_FIN;
                    end else if (rate != RATE_LOW) begin
                        rate  <= RATE_LOW;
                        state <= ST_BW;
                    end else
                        state <= ST_FIN;
                end
                ST_FIN:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dplt_train_chk.sv
module dplt_train_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic [7:0]  sink_rev,
    input logic        cmd_req,
    input logic        cmd_write,
    input logic [11:0] cmd_addr,
    input logic [31:0] cmd_wdata,
    input logic        cmd_ack,
    input logic        cmd_err,
    input logic        hpd_mask,
    input logic        done,
    input logic        success
);
    AST_MASK_WHILE_CMD: assert property (@(posedge clk) disable iff (rst)
        cmd_req |-> hpd_mask);                                         // R1
    AST_UNMASK_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        done |-> !hpd_mask && !cmd_req);                               // R1
    AST_EF_BIT: assert property (@(posedge clk) disable iff (rst)
        (cmd_req && cmd_write && cmd_addr == 12'h101)
            |-> cmd_wdata[7] == (sink_rev >= 8'h11));                  // R2
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (cmd_req && !cmd_ack) |=> cmd_req && $stable(cmd_addr)
                                  && $stable(cmd_wdata));              // R3
    AST_ERR_ENDS: assert property (@(posedge clk) disable iff (rst)
        (cmd_req && cmd_ack && cmd_err) |=> done && !success);         // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                               // R12
    AST_SUCCESS_HELD: assert property (@(posedge clk) disable iff (rst)
        (!start && !done && !hpd_mask) |=> $stable(success));          // R12
endmodule

bind dplt_train_seq dplt_train_chk u_chk (
    .clk(clk), .rst(rst), .start(start), .sink_rev(sink_rev),
    .cmd_req(cmd_req), .cmd_write(cmd_write), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .cmd_ack(cmd_ack), .cmd_err(cmd_err),
    .hpd_mask(hpd_mask), .done(done), .success(success));

// File: tb/dplt_train_seq_tb.sv
module dplt_train_seq_tb;
    localparam int CPU    = 2;
    localparam int CR_CYC = 100 * CPU;
    localparam int EQ_CYC = 400 * CPU;

    typedef struct packed {
        logic [7:0] rev;
        logic [2:0] lanes;
        logic [7:0] rate;
        logic [3:0] cr_need;
        logic [3:0] eq_need;
        logic       high_bad;
        logic       ramp;
        logic       lose_cr;
        logic [3:0] err_at;
        logic       exp_ok;
        logic [7:0] exp_rate;
        logic [4:0] exp_cr;
        logic [4:0] exp_eq;
        logic [1:0] exp_bw;
        logic [7:0] exp_lane;
        logic [7:0] exp_drive;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{8'h12, 3'd4, 8'h0A, 4'd1, 4'd1, 1'b0, 1'b0, 1'b0, 4'd0, 1'b1, 8'h0A, 5'd1,  5'd1,  2'd1, 8'h84, 8'h00},
        '{8'h10, 3'd2, 8'h0A, 4'd3, 4'd2, 1'b0, 1'b0, 1'b0, 4'd0, 1'b1, 8'h0A, 5'd3,  5'd2,  2'd1, 8'h02, 8'h00},
        '{8'h11, 3'd1, 8'h06, 4'd0, 4'd0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 8'h06, 5'd5,  5'd0,  2'd1, 8'h81, 8'h00},
        '{8'h12, 3'd4, 8'h0A, 4'd1, 4'd1, 1'b1, 1'b0, 1'b0, 4'd0, 1'b1, 8'h06, 5'd6,  5'd1,  2'd2, 8'h84, 8'h00},
        '{8'h11, 3'd4, 8'h06, 4'd0, 4'd0, 1'b0, 1'b1, 1'b0, 4'd0, 1'b0, 8'h06, 5'd4,  5'd0,  2'd1, 8'h84, 8'h27},
        '{8'h11, 3'd4, 8'h06, 4'd1, 4'd0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 8'h06, 5'd1,  5'd6,  2'd1, 8'h84, 8'h00},
        '{8'h11, 3'd4, 8'h0A, 4'd1, 4'd0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 8'h06, 5'd2,  5'd12, 2'd2, 8'h84, 8'h00},
        '{8'h11, 3'd4, 8'h06, 4'd1, 4'd0, 1'b0, 1'b0, 1'b1, 4'd0, 1'b0, 8'h06, 5'd1,  5'd1,  2'd1, 8'h84, 8'h00},
        '{8'h11, 3'd4, 8'h0A, 4'd1, 4'd1, 1'b0, 1'b0, 1'b0, 4'd3, 1'b0, 8'h0A, 5'd0,  5'd0,  2'd1, 8'h84, 8'hFF}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  sink_rev = '0;
    logic [2:0]  lane_cnt = 3'd4;
    logic [7:0]  rate_init = 8'h0A;
    logic        cmd_req, cmd_write;
    logic [11:0] cmd_addr;
    logic [1:0]  cmd_len;
    logic [31:0] cmd_wdata;
    logic        cmd_ack = 1'b0;
    logic        cmd_err = 1'b0;
    logic [23:0] cmd_rdata = '0;
    logic        hpd_mask, done, success;
    logic [7:0]  rate_out;

    int checks = 0;
    int errors = 0;

    vec_t v;
    int   cyc = 0, ncmd, tot_cr, tot_eq, nbw, cr_cnt, eq_cnt, adj_cnt, t_mark;
    logic [7:0] cur_rate, lane_seen, drive_last, pat_last;
    logic       hpd_bad, wait_bad;

    always #5 clk = ~clk;

    dplt_train_seq #(.CYC_PER_US(CPU)) u_dut (
        .clk(clk), .rst(rst), .start(start), .sink_rev(sink_rev),
        .lane_cnt(lane_cnt), .rate_init(rate_init), .cmd_req(cmd_req),
        .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
        .cmd_wdata(cmd_wdata), .cmd_ack(cmd_ack), .cmd_err(cmd_err),
        .cmd_rdata(cmd_rdata), .hpd_mask(hpd_mask), .done(done),
        .success(success), .rate_out(rate_out));

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Sink model: acknowledges on the falling edge after a request.
    initial begin
        v = VECS[0];
        forever begin
            @(negedge clk);
            cyc++;
            if (cmd_ack) begin
                cmd_ack = 1'b0;
                cmd_err = 1'b0;
            end else if (cmd_req) begin
                logic pass;
                logic [3:0] nib;
                ncmd++;
                if (!hpd_mask) hpd_bad = 1'b1;
                cmd_ack   = 1'b1;
                cmd_rdata = '0;
                if (ncmd == int'(v.err_at)) cmd_err = 1'b1;
                else if (cmd_write) begin
                    case (cmd_addr)
                        12'h100: begin cur_rate = cmd_wdata[7:0]; nbw++; end
                        12'h101: lane_seen = cmd_wdata[7:0];
                        12'h102: begin
                            pat_last = cmd_wdata[7:0];
                            t_mark   = cyc;
                            adj_cnt  = 0;
                            if (pat_last == 8'd1) cr_cnt = 0;
                            if (pat_last == 8'd2) eq_cnt = 0;
                        end
                        12'h103: begin drive_last = cmd_wdata[7:0]; t_mark = cyc; end
                        default: ;
                    endcase
                end else if (cmd_addr == 12'h202 && cmd_len == 2'd1) begin
                    tot_cr++; cr_cnt++;
                    if (cyc - t_mark < CR_CYC) wait_bad = 1'b1;
                    pass = (v.cr_need != 0) && (cr_cnt >= int'(v.cr_need)) &&
                           !(v.high_bad && cur_rate == 8'h0A);
                    for (int i = 0; i < int'(v.lanes); i++)
                        cmd_rdata[4*i +: 4] = pass ? 4'h1 : 4'h0;
                end else if (cmd_addr == 12'h202) begin
                    tot_eq++; eq_cnt++;
                    if (cyc - t_mark < EQ_CYC) wait_bad = 1'b1;
                    pass = (v.eq_need != 0) && (eq_cnt >= int'(v.eq_need));
                    nib  = pass ? 4'h7 : (v.lose_cr ? 4'h0 : 4'h1);
                    for (int i = 0; i < int'(v.lanes); i++)
                        cmd_rdata[4*i +: 4] = nib;
                    cmd_rdata[16] = pass;
                end else begin
                    adj_cnt++;
                    nib = v.ramp ? 4'((adj_cnt > 3) ? 3 : adj_cnt) : 4'h0;
                    for (int i = 0; i < int'(v.lanes); i++)
                        cmd_rdata[4*i +: 4] = nib;
                end
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R12 reset done",    32'(done),    32'd0);
        check("R12 reset success", 32'(success), 32'd0);
        check("R1 reset hpd_mask", 32'(hpd_mask), 32'd0);
        check("R12 reset cmd_req", 32'(cmd_req), 32'd0);

        for (int n = 0; n < NV; n++) begin
            v = VECS[n];
            sink_rev = v.rev; lane_cnt = v.lanes; rate_init = v.rate;
            ncmd = 0; tot_cr = 0; tot_eq = 0; nbw = 0; cr_cnt = 0;
            eq_cnt = 0; adj_cnt = 0; t_mark = 0;
            cur_rate = '0; lane_seen = '0; drive_last = 8'hEE; pat_last = 8'hEE;
            hpd_bad = 1'b0; wait_bad = 1'b0;
            @(negedge clk); start = 1'b1;
            @(negedge clk); start = 1'b0;
            while (!done) @(negedge clk);
            $display("vector %0d", n);
            check("R10/R9 success",   32'(success),  32'(v.exp_ok));
            check("R10/R11 rate_out", 32'(rate_out), 32'(v.exp_rate));
            check("R1 unmask at done", 32'(hpd_mask), 32'd0);
            check("R1 mask during cmds", 32'(hpd_bad), 32'd0);
            check("R2 lane byte",     32'(lane_seen), 32'(v.exp_lane));
            check("R5/R6 cr reads",   32'(tot_cr),   32'(v.exp_cr));
            check("R8 eq reads",      32'(tot_eq),   32'(v.exp_eq));
            check("R10 rate writes",  32'(nbw),      32'(v.exp_bw));
            check("R3 wait length",   32'(wait_bad), 32'd0);
            if (v.exp_drive != 8'hFF)
                check("R7 last drive", 32'(drive_last), 32'(v.exp_drive));
            if (v.err_at != 0)
                check("R11 no cmd after err", 32'(ncmd), 32'(v.err_at));
            else
                check("R10 pattern off", 32'(pat_last), 32'd0);
            @(negedge clk);
            check("R12 done pulse",   32'(done),    32'd0);
            check("R12 success held", 32'(success), 32'(v.exp_ok));
        end

        // R4: inactive lanes return zero status yet a 2-lane run passes (vector 1).
        check("R4 inactive lanes ignored", 32'(VECS[1].exp_ok), 32'd1);
        repeat (20) @(negedge clk);
        check("R12 rate held idle", 32'(rate_out), 32'(VECS[NV-1].exp_rate));
        check("R1 idle unmasked",   32'(hpd_mask), 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule